// File: doc/BRIEF.md
# Mirrored-Pair Frame Scheduler for a Folded DFT Engine

This controller runs one channel's detection window through a folded recursive DFT engine. The engine consumes two samples per cycle: sample n of a frame and its mirror N-1-n. The controller therefore drives two read addresses into a dual-port sample buffer at the same time. It walks a fixed schedule of short and long frames. Before each frame it raises a one-cycle engine reset, drives a coefficient index that names the frame, and counts the compute cycles.

The buffer has 318 entries. A long (212-sample) frame sits at addresses 0 to 211, and a short (106-sample) frame sits at 212 to 317. A window holds six short frames followed by eight long frames. The first short frame waits out an input fill latency of half a short frame before it computes. The whole window lasts 1233 cycles, counted from the first engine reset to the last compute cycle. A one-cycle strobe follows the window. A new window starts from a start strobe while the controller is idle.

Top module: `pair_fetch_sched`

## Requirements
- R1: After reset, eng_rst, eng_en, frame_done and win_done are all 0 and coef_sel is 0, and they stay that way until start is seen.
- R2: A start sampled high while idle makes the next cycle an engine-reset cycle with coef_sel = 0.
- R3: Every frame of a window is preceded by exactly one cycle with eng_rst = 1 and eng_en = 0. Frames run in index order 0 to 13, and coef_sel equals the frame index from that frame's reset cycle through its last compute cycle.
- R4: Only frame 0 is followed by a fill phase after its reset cycle. The fill phase is 53 cycles with both eng_rst and eng_en at 0.
- R5: Frames 0 to 5 are short (N = 106, base 212) and run 53 compute cycles. Frames 6 to 13 are long (N = 212, base 0) and run 106 compute cycles. Compute cycles carry eng_en = 1.
- R6: In compute cycle n of a frame (n counted from 0), rd_addr_a = base + n and rd_addr_b = base + N - 1 - n.
- R7: frame_done is 1 exactly in the last compute cycle of each frame.
- R8: win_done is a one-cycle pulse in the cycle after the last compute cycle of frame 13. That last compute cycle is cycle 1233 of the window, with the first reset cycle counted as cycle 1.
- R9: A start that arrives while a window is in progress has no effect on the schedule.
- R10: A start sampled in the win_done cycle begins a new window in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Window start request, honoured only when idle |
| rd_addr_a | output | 9 | Buffer address of sample n of the current frame |
| rd_addr_b | output | 9 | Buffer address of mirror sample N-1-n |
| eng_rst | output | 1 | Engine state clear, one cycle before each frame |
| eng_en | output | 1 | Engine compute enable |
| coef_sel | output | 4 | Coefficient index, equal to the frame index |
| frame_done | output | 1 | Last compute cycle of a frame |
| win_done | output | 1 | One-cycle pulse after the window ends |

## Verification
The bench derives the whole window schedule arithmetically. For every cycle it knows the phase (reset, fill or compute), the frame index, and the expected address pair. It compares all outputs in every cycle of two windows. The first window is started from idle and receives a stray start in the middle of a long frame. Any restart or skipped cycle would then shift every later expected value. The second window is requested in the win_done cycle itself, which separates a correct back-to-back start from one that loses or delays a cycle. After that the start input stays low, which shows that the block returns to idle and holds there.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RST  = 2'd1,
        ST_FILL = 2'd2,
        ST_RUN  = 2'd3
    } sched_state_e;
endpackage

// File: rtl/frame_cfg.sv
module frame_cfg #(
    parameter int SHORT_LEN = 106,
    parameter int LONG_LEN  = 212,
    parameter int SHORT_CNT = 6,
    parameter int FRM_W     = 4,
    parameter int CNT_W     = 7,
    parameter int ADDR_W    = 9
) (
    input  logic [FRM_W-1:0]  frame_idx,
    output logic [CNT_W-1:0]  half_m1,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] span_m1
);
    localparam logic [CNT_W-1:0]  LHALF_M1 = CNT_W'(LONG_LEN / 2 - 1);
    localparam logic [CNT_W-1:0]  SHALF_M1 = CNT_W'(SHORT_LEN / 2 - 1);
    localparam logic [ADDR_W-1:0] LBASE    = '0;
    localparam logic [ADDR_W-1:0] SBASE    = ADDR_W'(LONG_LEN);
    localparam logic [ADDR_W-1:0] LSPAN_M1 = ADDR_W'(LONG_LEN - 1);
    localparam logic [ADDR_W-1:0] SSPAN_M1 = ADDR_W'(SHORT_LEN - 1);
    localparam logic [FRM_W-1:0]  FIRST_LONG = FRM_W'(SHORT_CNT);

    logic is_long;

    always_comb begin
        is_long = (frame_idx >= FIRST_LONG);
        half_m1 = is_long ? LHALF_M1 : SHALF_M1;
        base    = is_long ? LBASE    : SBASE;
        span_m1 = is_long ? LSPAN_M1 : SSPAN_M1;
    end
endmodule

// File: rtl/pair_addr.sv
module pair_addr #(
    parameter int CNT_W  = 7,
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] span_m1,
    input  logic [CNT_W-1:0]  pair,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi
);
    logic [ADDR_W-1:0] pair_ext;

    always_comb begin
        pair_ext = ADDR_W'(pair);
        addr_lo  = base + pair_ext;
        addr_hi  = base + (span_m1 - pair_ext);
    end
endmodule

// File: rtl/pair_fetch_sched.sv
module pair_fetch_sched #(
    parameter int SHORT_LEN = 106,
    parameter int LONG_LEN  = 212,
    parameter int SHORT_CNT = 6,
    parameter int LONG_CNT  = 8,
    localparam int FRAMES   = SHORT_CNT + LONG_CNT,
    localparam int FRM_W    = $clog2(FRAMES),
    localparam int ADDR_W   = $clog2(SHORT_LEN + LONG_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [ADDR_W-1:0] rd_addr_b,
    output logic              eng_rst,
    output logic              eng_en,
    output logic [FRM_W-1:0]  coef_sel,
    output logic              frame_done,
    output logic              win_done
);
    import sched_pkg::*;

    localparam int              CNT_W      = $clog2(LONG_LEN / 2);
    localparam logic [CNT_W-1:0] FILL_M1   = CNT_W'(SHORT_LEN / 2 - 1);
    localparam logic [FRM_W-1:0] LAST_FRM  = FRM_W'(FRAMES - 1);

    typedef struct packed {
        sched_state_e     st;
        logic [FRM_W-1:0] frame;
        logic [CNT_W-1:0] cnt;
        logic             wdone;
    } sched_regs_t;

    sched_regs_t r_d, r_q;

    logic [CNT_W-1:0]  half_m1;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] span_m1;
    logic [CNT_W-1:0]  pair_sel;

    frame_cfg #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .SHORT_CNT (SHORT_CNT),
        .FRM_W     (FRM_W),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W)
    ) u_cfg (
        .frame_idx (r_q.frame),
        .half_m1   (half_m1),
        .base      (base),
        .span_m1   (span_m1)
    );

    assign pair_sel = (r_q.st == ST_RUN) ? r_q.cnt : '0;

    pair_addr #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .base    (base),
        .span_m1 (span_m1),
        .pair    (pair_sel),
        .addr_lo (rd_addr_a),
        .addr_hi (rd_addr_b)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wdone = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_RST;
                    r_d.frame = '0;
                    r_d.cnt   = '0;
                end
            end
            ST_RST: begin
                r_d.cnt = '0;
                r_d.st  = (r_q.frame == '0) ? ST_FILL : ST_RUN;
            end
            ST_FILL: begin
                if (r_q.cnt == FILL_M1) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_RUN;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (r_q.cnt == half_m1) begin
                    r_d.cnt = '0;
                    if (r_q.frame == LAST_FRM) begin
                        r_d.st    = ST_IDLE;
                        r_d.wdone = 1'b1;
                    end else begin
                        r_d.frame = r_q.frame + 1'b1;
                        r_d.st    = ST_RST;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, frame: '0, cnt: '0, wdone: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign eng_rst    = (r_q.st == ST_RST);
    assign eng_en     = (r_q.st == ST_RUN);
    assign frame_done = (r_q.st == ST_RUN) && (r_q.cnt == half_m1);
    assign coef_sel   = r_q.frame;
    assign win_done   = r_q.wdone;
endmodule

// File: rtl/pair_fetch_sched_chk.sv
module pair_fetch_sched_chk #(
    parameter int SHORT_LEN = 106,
    parameter int LONG_LEN  = 212,
    parameter int SHORT_CNT = 6,
    parameter int LONG_CNT  = 8,
    parameter int FRM_W     = 4,
    parameter int ADDR_W    = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic              eng_rst,
    input logic              eng_en,
    input logic [FRM_W-1:0]  coef_sel,
    input logic              frame_done,
    input logic              win_done
);
    localparam int WIN_CYC = SHORT_CNT + LONG_CNT + SHORT_LEN / 2
                           + SHORT_CNT * (SHORT_LEN / 2) + LONG_CNT * (LONG_LEN / 2);
    localparam int SUM_S   = 2 * LONG_LEN + SHORT_LEN - 1;
    localparam int SUM_L   = LONG_LEN - 1;
    localparam int TOTAL   = SHORT_LEN + LONG_LEN;

    logic [15:0] win_cyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cyc_q <= '0;
        end else if (win_done) begin
            win_cyc_q <= '0;
        end else if (eng_rst && coef_sel == '0) begin
            win_cyc_q <= 16'd1;
        end else if (win_cyc_q != '0) begin
            win_cyc_q <= win_cyc_q + 16'd1;
        end
    end

    a_r3_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst |=> !eng_rst);
    a_r3_rst_en_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_rst && eng_en));
    a_r3_coef_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eng_rst) && coef_sel != '0) |-> coef_sel == $past(coef_sel) + 1'b1);
    a_r6_mirror_sum: assert property (@(posedge clk) disable iff (!rst_n)
        eng_en |-> (32'(rd_addr_a) + 32'(rd_addr_b) ==
                    ((32'(coef_sel) < SHORT_CNT) ? SUM_S : SUM_L)));
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_en && $past(eng_en)) |-> rd_addr_a == $past(rd_addr_a) + 1'b1);
    a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        eng_en |-> (32'(rd_addr_a) < TOTAL && 32'(rd_addr_b) < TOTAL));
    a_r7_done_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> eng_en);
    a_r8_win_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);
    a_r8_win_length: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> 32'(win_cyc_q) == WIN_CYC);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_en && !frame_done) |=> !(eng_rst && coef_sel == '0));
endmodule

bind pair_fetch_sched pair_fetch_sched_chk #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN),
    .SHORT_CNT (SHORT_CNT),
    .LONG_CNT  (LONG_CNT),
    .FRM_W     (FRM_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_addr_a  (rd_addr_a),
    .rd_addr_b  (rd_addr_b),
    .eng_rst    (eng_rst),
    .eng_en     (eng_en),
    .coef_sel   (coef_sel),
    .frame_done (frame_done),
    .win_done   (win_done)
);

// File: tb/tb_pair_fetch_sched.sv
module tb_pair_fetch_sched;
    localparam int SHORT_LEN = 106;
    localparam int LONG_LEN  = 212;
    localparam int SHORT_CNT = 6;
    localparam int LONG_CNT  = 8;
    localparam int FRAMES    = SHORT_CNT + LONG_CNT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] rd_addr_a, rd_addr_b;
    logic       eng_rst, eng_en, frame_done, win_done;
    logic [3:0] coef_sel;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    pair_fetch_sched #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .SHORT_CNT (SHORT_CNT),
        .LONG_CNT  (LONG_CNT)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rd_addr_a  (rd_addr_a),
        .rd_addr_b  (rd_addr_b),
        .eng_rst    (eng_rst),
        .eng_en     (eng_en),
        .coef_sel   (coef_sel),
        .frame_done (frame_done),
        .win_done   (win_done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Compares control outputs; addresses only when chk_addr is set.
    task automatic expect_out(input string tag, input bit x_rst, input bit x_en,
                              input int x_coef, input bit chk_addr, input int x_a,
                              input int x_b, input bit x_fd, input bit x_wd);
        n_chk++;
        if (eng_rst !== x_rst || eng_en !== x_en || int'(coef_sel) != x_coef ||
            frame_done !== x_fd || win_done !== x_wd ||
            (chk_addr && (int'(rd_addr_a) != x_a || int'(rd_addr_b) != x_b))) begin
            n_fail++;
            $display("FAIL %s: actual rst=%0b en=%0b coef=%0d a=%0d b=%0d fd=%0b wd=%0b expected rst=%0b en=%0b coef=%0d a=%0d b=%0d fd=%0b wd=%0b",
                     tag, eng_rst, eng_en, coef_sel, rd_addr_a, rd_addr_b, frame_done, win_done,
                     x_rst, x_en, x_coef, x_a, x_b, x_fd, x_wd);
        end
    endtask

    // Called at the negedge inside the first reset cycle of a window.
    // inject: cycle index (0 = first reset cycle) at which a stray start is driven, -1 none.
    // chain: drive start in the win_done cycle.
    task automatic run_window(input int inject, input bit chain);
        int k = 0;
        int span_cnt = 0;
        for (int f = 0; f < FRAMES; f++) begin
            bit  lng  = (f >= SHORT_CNT);
            int  nlen = lng ? LONG_LEN : SHORT_LEN;
            int  base = lng ? 0 : LONG_LEN;
            // R3: one reset cycle, coef_sel = frame index
            expect_out((k == inject + 1) ? "R9 reset" : "R3 reset", 1'b1, 1'b0, f, 1'b0, 0, 0, 1'b0, 1'b0);
            start = (k == inject); @(negedge clk); k++; span_cnt++;
            if (f == 0) begin
                for (int i = 0; i < SHORT_LEN / 2; i++) begin
                    expect_out("R4 fill", 1'b0, 1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b0);
                    start = (k == inject); @(negedge clk); k++; span_cnt++;
                end
            end
            for (int n = 0; n < nlen / 2; n++) begin
                expect_out((k == inject + 1) ? "R9 compute" :
                           ((n == nlen / 2 - 1) ? "R7 last" : "R5/R6 compute"),
                           1'b0, 1'b1, f, 1'b1, base + n, base + nlen - 1 - n,
                           (n == nlen / 2 - 1), 1'b0);
                start = (k == inject); @(negedge clk); k++; span_cnt++;
            end
        end
        // R8: pulse in the cycle after the last compute cycle; window span 1233 cycles
        n_chk++;
        if (span_cnt != 1233) begin
            n_fail++;
            $display("FAIL R8 span: actual %0d expected 1233", span_cnt);
        end
        expect_out("R8 win_done", 1'b0, 1'b0, FRAMES - 1, 1'b0, 0, 0, 1'b0, 1'b1);
        start = chain; @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle state after reset, held without start
        for (int i = 0; i < 4; i++) begin
            expect_out("R1 idle", 1'b0, 1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b0);
            @(negedge clk);
        end
        // R2: start from idle
        start = 1'b1; @(negedge clk); start = 1'b0;
        // first window: stray start mid long frame (R9), chained restart at win_done (R10)
        run_window(700, 1'b1);
        // R10: new window begins right after the win_done cycle
        expect_out("R10 chain", 1'b1, 1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b0);
        run_window(-1, 1'b0);
        // no start: stays idle, win_done gone
        for (int i = 0; i < 3; i++) begin
            expect_out("R1 idle after window", 1'b0, 1'b0, FRAMES - 1, 1'b0, 0, 0, 1'b0, 1'b0);
            @(negedge clk);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule